// File: doc/BRIEF.md
# Eight-Channel Sampled-Value Serial Responder

This block plays the serial side of an eight-channel, 12-bit converter. A host acting as SPI master lowers chip select, runs sixteen serial clock cycles, sends a 3-bit channel number early in that frame, and reads a 12-bit unsigned code (0 to 4095 for 0 V to 3.3 V full scale) back in its last twelve positions. The codes are not converted here. They are written into eight sample registers through a parallel write port by the surrounding logic or a testbench.

All three serial inputs come from another clock domain. Each passes through a two-flop synchronizer into a fast system clock, and edges are found on the synchronized serial clock. The channel number received in one frame selects the code returned in the following frame. The code to be sent is captured at the moment its first bit goes out, so that register writes during a frame cannot corrupt the word being shifted.

Top module: `adc_frame_responder`

## Requirements
- R1: A frame is complete only after 16 rising edges of the serial clock while chip select is low. Positions are numbered 0 to 15, and position p starts at the p-th falling edge and is sampled at the p-th rising edge.
- R2: The data-in values at positions 0 and 1 have no effect on the channel selected or on any output.
- R3: Positions 2, 3 and 4 carry the channel number on data-in, most significant bit first (position 2 is bit 2). A completed frame's number selects the channel whose code the next frame returns.
- R4: Positions 4 to 15 carry the selected channel's 12-bit code on data-out, most significant bit first (position 4 is bit 11, position 15 is bit 0).
- R5: Data-out is 0 during positions 0 to 3 and whenever chip select is high.
- R6: Raising chip select before the 16th rising edge discards that frame's partial channel number, and the previously selected channel stays in force.
- R7: The code sent in a frame is captured at the falling edge that starts position 4. A write to that channel after this point leaves the current frame unchanged and shows in later frames.
- R8: When the write strobe is high at a system clock edge, the write data is stored in the sample register named by the 3-bit write address. Writes are accepted at any time.
- R9: After reset, data-out is 0 and the first frame returns channel 0.
- R10: Data-out changes only after a serial clock falling edge and data-in is sampled at rising edges. Each takes effect three system clock cycles after the pin edge, and the serial clock idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles high, asynchronous |
| din | input | 1 | Serial data from the master (channel number) |
| dout | output | 1 | Serial data to the master (sample code) |
| sampleWe | input | 1 | Sample register write strobe |
| sampleAddr | input | 3 | Sample register index 0 to 7 |
| sampleData | input | 12 | Code to store |

## Verification
A serial pin edge reaches the block's logic after two synchronizer flops and one edge-detect flop, so data-out moves three system clocks after a serial falling edge. The bench holds each serial clock half-period for eight system clocks and reads data-out one system clock before the next rising edge, well after the update has landed. It reads data-out again at the end of the high half to show that nothing moved between the two falling edges. A register write is due one system clock after its strobe, and channel selection is due one frame after the frame that carried the number, so each expected word is computed from the bench's own model of the sample registers and the selected channel, taken before the frame starts.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

  // Strobes from the serial control to the datapath; at most one of
  // idle/addrShift/commit/loadOut/shiftOut is high in any cycle.
  typedef struct packed {
    logic idle;       // chip select inactive: clear output
    logic frameStart; // chip select just became active
    logic addrShift;  // shift a channel-number bit in
    logic commit;     // frame complete: adopt new channel
    logic loadOut;    // capture selected code, drive MSB
    logic shiftOut;   // drive next code bit
  } respStrobes_t;

endpackage

// File: rtl/adc_resp_sync.sv
module adc_resp_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/adc_resp_ctrl.sv
module adc_resp_ctrl
  import adc_resp_pkg::*;
#(
  parameter int FRAME_LEN   = 16,
  parameter int SAMPLE_W    = 12,
  parameter int CH_W        = 3,
  parameter int ADDR_FIRST  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             din,
  output respStrobes_t     strb,
  output logic             dinBit,
  output logic [POS_W-1:0] posCnt
);

  localparam int DATA_FIRST = FRAME_LEN - SAMPLE_W;
  localparam logic [POS_W-1:0] POS_LAST   = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] POS_END    = POS_W'(FRAME_LEN);
  localparam logic [POS_W-1:0] POS_DATA   = POS_W'(DATA_FIRST);
  localparam logic [POS_W-1:0] POS_ADDR0  = POS_W'(ADDR_FIRST);
  localparam logic [POS_W-1:0] POS_ADDRN  = POS_W'(ADDR_FIRST + CH_W - 1);

  logic csS, sclkS, dinS;
  logic [2:0] syncIn, syncOut;
  localparam logic [2:0] SYNC_RST = 3'b011; // csN and sclk idle high

  assign syncIn = {din, sclk, csN};

  generate
    for (genvar g = 0; g < 3; g++) begin : g_sync
      adc_resp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST[g])) u_sync (
        .clk    (clk),
        .rstN   (rstN),
        .asyncIn(syncIn[g]),
        .syncOut(syncOut[g])
      );
    end
  endgenerate

  assign csS   = syncOut[0];
  assign sclkS = syncOut[1];
  assign dinS  = syncOut[2];

  logic sclkPrev, activePrev;
  logic csActive, riseEdge, fallEdge;

  assign csActive = ~csS;
  assign riseEdge = csActive & sclkS & ~sclkPrev;
  assign fallEdge = csActive & ~sclkS & sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev   <= 1'b1;
      activePrev <= 1'b0;
    end else begin
      sclkPrev   <= sclkS;
      activePrev <= csActive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              posCnt <= '0;
    else if (!csActive)                     posCnt <= '0;
    else if (riseEdge && posCnt < POS_END)  posCnt <= posCnt + 1'b1;
  end

  always_comb begin
    strb            = '0;
    strb.idle       = ~csActive;
    strb.frameStart = csActive & ~activePrev;
    strb.addrShift  = riseEdge && posCnt >= POS_ADDR0 && posCnt <= POS_ADDRN;
    strb.commit     = riseEdge && posCnt == POS_LAST;
    strb.loadOut    = fallEdge && posCnt == POS_DATA;
    strb.shiftOut   = fallEdge && posCnt > POS_DATA && posCnt < POS_END;
  end

  assign dinBit = dinS;

endmodule

// File: rtl/adc_resp_dp.sv
module adc_resp_dp
  import adc_resp_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 12,
  parameter int CH_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  respStrobes_t        strb,
  input  logic                dinBit,
  input  logic                sampleWe,
  input  logic [CH_W-1:0]     sampleAddr,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                dout,
  output logic [CH_W-1:0]     chanSel
);

  logic [SAMPLE_W-1:0] bank [NUM_CH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      bank[c] <= '0;
        else if (sampleWe && sampleAddr == CH_W'(c))    bank[c] <= sampleData;
      end
    end
  endgenerate

  logic [CH_W-1:0]     addrShiftReg;
  logic [SAMPLE_W-1:0] outShift;
  logic [SAMPLE_W-1:0] selCode;

  assign selCode = bank[chanSel];

  // channel number capture and adoption
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShiftReg <= '0;
      chanSel      <= '0;
    end else begin
      if (strb.frameStart)     addrShiftReg <= '0;
      else if (strb.addrShift) addrShiftReg <= (addrShiftReg << 1) | CH_W'(dinBit);
      if (strb.commit)         chanSel <= addrShiftReg;
    end
  end

  // code serializer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      dout     <= 1'b0;
    end else if (strb.idle) begin
      outShift <= '0;
      dout     <= 1'b0;
    end else if (strb.loadOut) begin
      dout     <= selCode[SAMPLE_W-1];
      outShift <= selCode << 1;
    end else if (strb.shiftOut) begin
      dout     <= outShift[SAMPLE_W-1];
      outShift <= outShift << 1;
    end
  end

endmodule

// File: rtl/adc_frame_responder.sv
module adc_frame_responder
  import adc_resp_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SAMPLE_W    = 12,
  parameter int FRAME_LEN   = 16,
  parameter int ADDR_FIRST  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclk,
  input  logic          din,
  output logic          dout,
  input  logic          sampleWe,
  input  logic [2:0]    sampleAddr,
  input  logic [11:0]   sampleData
);

  localparam int CH_W       = $clog2(NUM_CH);
  localparam int POS_W      = $clog2(FRAME_LEN + 1);
  localparam int DATA_FIRST = FRAME_LEN - SAMPLE_W;

  respStrobes_t      strb;
  logic              dinBit;
  logic [POS_W-1:0]  posCnt;
  logic [CH_W-1:0]   chanSel;

  adc_resp_ctrl #(
    .FRAME_LEN  (FRAME_LEN),
    .SAMPLE_W   (SAMPLE_W),
    .CH_W       (CH_W),
    .ADDR_FIRST (ADDR_FIRST),
    .SYNC_STAGES(SYNC_STAGES),
    .POS_W      (POS_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .din   (din),
    .strb  (strb),
    .dinBit(dinBit),
    .posCnt(posCnt)
  );

  adc_resp_dp #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .CH_W    (CH_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dinBit    (dinBit),
    .sampleWe  (sampleWe),
    .sampleAddr(CH_W'(sampleAddr)),
    .sampleData(SAMPLE_W'(sampleData)),
    .dout      (dout),
    .chanSel   (chanSel)
  );

endmodule

// File: rtl/adc_frame_responder_chk.sv
module adc_frame_responder_chk
  import adc_resp_pkg::*;
#(
  parameter int POS_W      = 5,
  parameter int CH_W       = 3,
  parameter int DATA_FIRST = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             dout,
  input respStrobes_t     strb,
  input logic [POS_W-1:0] posCnt,
  input logic [CH_W-1:0]  chanSel
);

  // R5: output cleared while chip select is inactive
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> !dout);

  // R5: output low through the leading positions of a frame
  a_r5_lead_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.idle && posCnt < POS_W'(DATA_FIRST)) |-> !dout);

  // R1: control never issues two datapath actions at once
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.idle, strb.addrShift, strb.commit, strb.loadOut, strb.shiftOut}));

  // R6: selected channel only moves at frame completion
  a_r6_chan_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(chanSel));

  // R10: output moves only on a serial falling edge action or idle clear
  a_r10_dout_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.idle || strb.loadOut || strb.shiftOut) |=> $stable(dout));

endmodule

bind adc_frame_responder adc_frame_responder_chk #(
  .POS_W     (POS_W),
  .CH_W      (CH_W),
  .DATA_FIRST(DATA_FIRST)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .dout   (dout),
  .strb   (strb),
  .posCnt (posCnt),
  .chanSel(chanSel)
);

// File: tb/adc_frame_responder_bench.sv
module adc_frame_responder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // system clocks per serial half-period
  localparam int NCH        = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic dout;
  logic sampleWe = 1'b0;
  logic [2:0]  sampleAddr = '0;
  logic [11:0] sampleData = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [11:0] mdl [NCH];
  int curChan = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_responder u_adc_frame_responder (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .dout(dout),
    .sampleWe(sampleWe), .sampleAddr(sampleAddr), .sampleData(sampleData)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // R8: write one sample register through the parallel port
  task automatic writeSample(int ch, logic [11:0] v);
    @(negedge clk);
    sampleWe = 1'b1; sampleAddr = 3'(ch); sampleData = v;
    @(negedge clk);
    sampleWe = 1'b0;
    mdl[ch] = v;
  endtask

  // stopAfter: number of rising edges before chip select is raised (16 = full)
  task automatic runFrame(logic [2:0] addr, logic [1:0] junk, int stopAfter,
                          int midWrite, string tag);
    logic [11:0] got = '0;
    logic [11:0] exp = mdl[curChan];
    bit leadBad = 1'b0;
    bit moveBad = 1'b0;
    logic lastSeen;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int p = 0; p < 16; p++) begin
      if (p == stopAfter) break;
      sclk = 1'b0;
      if (p < 2)      din = junk[1-p];
      else if (p < 5) din = addr[4-p];
      else            din = 1'($urandom);
      if (midWrite >= 0 && p == 6) begin
        writeSample(curChan, 12'(midWrite));
        repeat (HALF-2) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      lastSeen = dout;
      if (p < 4) begin
        if (dout !== 1'b0) leadBad = 1'b1;
      end else begin
        got[15-p] = dout;
      end
      sclk = 1'b1;
      repeat (HALF-1) @(negedge clk);
      if (dout !== lastSeen) moveBad = 1'b1;
      @(negedge clk);
    end
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    if (stopAfter >= 16) begin
      check({"R4 R3 code ", tag}, 32'(got), 32'(exp));
      check({"R5 lead zero ", tag}, 32'(leadBad), 32'd0);
      check({"R10 stable in high half ", tag}, 32'(moveBad), 32'd0);
      curChan = int'(addr);
    end
    check({"R5 idle zero ", tag}, 32'(dout), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) mdl[c] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset dout", 32'(dout), 32'd0);

    for (int c = 0; c < NCH; c++) writeSample(c, 12'($urandom));
    writeSample(2, 12'hFFF);
    writeSample(3, 12'h000);
    writeSample(6, 12'hA5A);

    runFrame(3'd2, 2'b00, 16, -1, "R9 first frame ch0");
    runFrame(3'd3, 2'b00, 16, -1, "R4 all ones ch2");
    runFrame(3'd6, 2'b11, 16, -1, "R2 junk ones zero code ch3");
    runFrame(3'd7, 2'b10, 16, -1, "R3 pattern ch6");
    // R6 / R1: aborted frames keep channel 7
    runFrame(3'd1, 2'b00, 3,  -1, "R6 abort early");
    runFrame(3'd4, 2'b00, 15, -1, "R1 fifteen clocks");
    runFrame(3'd0, 2'b01, 16, -1, "R6 channel kept ch7");
    // R7: mid-frame write to current channel 0
    runFrame(3'd0, 2'b00, 16, 12'h3C3, "R7 old value");
    runFrame(3'd5, 2'b00, 16, -1, "R7 new value");
    // R8: write between frames reaches the next frame
    writeSample(5, 12'h801);
    runFrame(3'd1, 2'b11, 16, -1, "R8 written ch5");

    for (int i = 0; i < 20; i++) begin
      if ($urandom % 2 == 0) writeSample(int'($urandom % NCH), 12'($urandom));
      runFrame(3'($urandom), 2'($urandom), 16, -1, "R3 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule